// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. It runs on the output clock of an external dual-modulus prescaler and steers that prescaler through a modulus-select output: divide by P+1 or divide by P. Two down counters run inside it. A swallow counter holds the number of prescaler cycles that still have to use the long modulus. A main counter holds the number of prescaler cycles left in the current output period. An output period lasts B prescaler cycles. The first A of them are long (P+1) and the rest are short (P). The divide ratio seen from the prescaler input is therefore B·P + A.

At the end of each output period the block emits a one-prescaler-cycle feedback pulse toward the phase/frequency detector. At the same edge it reloads both counters from the programmed A and B inputs. A and B are read only at that reload edge, so they may change at any time without disturbing a period already in progress. A registered error flag reports when the active pair has fewer main cycles than swallow cycles. B must be at least 2.

Top module: `pulse_swallow_div`

## Requirements
- R1: Every output period spans exactly B prescaler cycles, where B is the value of `b_set` sampled at the reload edge that starts the period.
- R2: Within a period, `mod_sel` is 1 (prescaler divides by P+1) for the first min(A, B) prescaler cycles and 0 (divide by P) for the rest.
- R3: Once `mod_sel` has dropped to 0 inside a period, it stays 0 until the next reload edge.
- R4: The period of `fb_pulse`, counted in prescaler input cycles, equals B·P + A for any legal pair (B ≥ A, B ≥ 2).
- R5: With A = 0, `mod_sel` stays 0 for the whole period and the ratio is B·P.
- R6: A change of `a_set` or `b_set` during a period, including a short excursion, has no effect on that period. The values present at the next reload edge govern the following period.
- R7: `cfg_err` is 1 for a period exactly when the loaded pair has B < A, and is constant within a period. In that case every one of the B prescaler cycles is long.
- R8: `rst` is synchronous to `pre_clk`. While it is high, `fb_pulse` is 0 and the counters load from `a_set`/`b_set`, so `mod_sel` reads 1 exactly when `a_set` is nonzero.
- R9: `fb_pulse` is high for exactly one prescaler cycle, the one that follows the reload edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pre_clk | input | 1 | Prescaler output clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_set | input | A_W (6) | Programmed swallow count A |
| b_set | input | B_W (13) | Programmed main count B |
| mod_sel | output | 1 | Modulus select to the prescaler: 1 = P+1, 0 = P |
| fb_pulse | output | 1 | One-cycle feedback pulse at each period end |
| cfg_err | output | 1 | Active pair has B < A |

## Verification
Every result appears one `pre_clk` edge after its cause. `mod_sel` and `cfg_err` settle at the reload edge. `fb_pulse` rises at that edge and falls at the next one. A new A/B pair first shows up in the period that begins at the reload edge following the change. The bench therefore samples on the falling edge of the prescaler input clock that follows each reload edge. It queues one expected record per period, and each record carries the settings that were present at that period's reload. The period that is already running when the settings change is held to the old values.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Main cycles actually run for a programmed B (zero behaves as one).
  function automatic logic [31:0] eff_main(input logic [31:0] b);
    return (b == 32'd0) ? 32'd1 : b;
  endfunction

  // Number of long (P+1) prescaler cycles in one period.
  function automatic logic [31:0] long_cycles(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m;
    m = eff_main(b);
    return (a < m) ? a : m;
  endfunction

  // Pair is illegal when fewer main cycles than swallow cycles.
  function automatic logic cfg_bad(input logic [31:0] a, input logic [31:0] b);
    return b < a;
  endfunction

  // Total divide ratio in prescaler input cycles.
  function automatic logic [31:0] ratio(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] p);
    return eff_main(b) * p + long_cycles(a, b);
  endfunction

endpackage

// File: rtl/psd_swallow_cnt.sv
// Swallow counter: counts long prescaler cycles down to zero and holds there.
module psd_swallow_cnt #(
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           load,
  input  logic [A_W-1:0] a_init,
  output logic           long_sel
);
  logic [A_W-1:0] a_rem;

  always_ff @(posedge clk) begin
    if (load)
      a_rem <= a_init;
    else if (a_rem != '0)
      a_rem <= a_rem - A_W'(1);
  end

  assign long_sel = (a_rem != '0);
endmodule

// File: rtl/psd_main_cnt.sv
// Main counter: counts prescaler cycles of the current period.
module psd_main_cnt #(
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           load,
  input  logic [B_W-1:0] b_init,
  output logic           last
);
  logic [B_W-1:0] b_rem;

  always_ff @(posedge clk) begin
    if (load)
      b_rem <= b_init;
    else
      b_rem <= b_rem - B_W'(1);
  end

  // Zero is treated like one so a bad setting cannot stall the divider.
  assign last = (b_rem <= B_W'(1));
endmodule

// File: rtl/psd_reload_ctrl.sv
// Reload sequencing, feedback pulse and configuration check.
module psd_reload_ctrl #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_last,
  input  logic [A_W-1:0] a_set,
  input  logic [B_W-1:0] b_set,
  output logic           load,
  output logic           fb_pulse,
  output logic           cfg_err
);
  assign load = rst | cyc_last;

  always_ff @(posedge clk) begin
    if (load)
      cfg_err <= psd_pkg::cfg_bad(32'(a_set), 32'(b_set));
    if (rst)
      fb_pulse <= 1'b0;
    else
      fb_pulse <= cyc_last;
  end
endmodule

// File: rtl/pulse_swallow_div.sv
// Dual-modulus pulse-swallow feedback divider, top level.
module pulse_swallow_div #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           pre_clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_set,
  input  logic [B_W-1:0] b_set,
  output logic           mod_sel,
  output logic           fb_pulse,
  output logic           cfg_err
);
  // Named internal events, observed by the bound checker.
  logic cyc_last;
  logic load;

  psd_reload_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
    .clk      (pre_clk),
    .rst      (rst),
    .cyc_last (cyc_last),
    .a_set    (a_set),
    .b_set    (b_set),
    .load     (load),
    .fb_pulse (fb_pulse),
    .cfg_err  (cfg_err)
  );

  psd_swallow_cnt #(.A_W(A_W)) u_swallow (
    .clk      (pre_clk),
    .load     (load),
    .a_init   (a_set),
    .long_sel (mod_sel)
  );

  psd_main_cnt #(.B_W(B_W)) u_main (
    .clk    (pre_clk),
    .load   (load),
    .b_init (b_set),
    .last   (cyc_last)
  );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input logic           clk,
  input logic           rst,
  input logic [A_W-1:0] a_set,
  input logic [B_W-1:0] b_set,
  input logic           mod_sel,
  input logic           fb_pulse,
  input logic           cfg_err,
  input logic           cyc_last
);
  logic [A_W-1:0] a_l;
  logic [B_W-1:0] b_l;
  logic [31:0]    pos;
  logic [31:0]    longs;
  logic [31:0]    long_exp;
  logic [31:0]    main_exp;

  // Checker-side copy of the active pair and position within the period.
  always_ff @(posedge clk) begin
    if (rst || cyc_last) begin
      a_l   <= a_set;
      b_l   <= b_set;
      pos   <= 32'd1;
      longs <= 32'd0;
    end else begin
      pos   <= pos + 32'd1;
      longs <= longs + 32'(mod_sel);
    end
  end

  assign long_exp = psd_pkg::long_cycles(32'(a_l), 32'(b_l));
  assign main_exp = psd_pkg::eff_main(32'(b_l));

  // R1: period length in prescaler cycles
  assert_period_len_R1: assert property (@(posedge clk) disable iff (rst)
    cyc_last |-> (pos == main_exp));

  // R2: number of long cycles per period
  assert_long_count_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_last |-> ((longs + 32'(mod_sel)) == long_exp));

  // R3: modulus select never returns high inside a period
  assert_mod_monotone_R3: assert property (@(posedge clk) disable iff (rst)
    (!mod_sel && !cyc_last) |=> !mod_sel);

  // R5: first cycle of a period is long only when A is nonzero
  assert_start_mod_R5: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> (mod_sel == (a_l != '0)));

  // R7: error flag constant within a period
  assert_err_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !cyc_last |=> $stable(cfg_err));

  // R9: feedback pulse lasts a single prescaler cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && main_exp > 32'd1) |=> !fb_pulse);
endmodule

bind pulse_swallow_div psd_checker #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk      (pre_clk),
  .rst      (rst),
  .a_set    (a_set),
  .b_set    (b_set),
  .mod_sel  (mod_sel),
  .fb_pulse (fb_pulse),
  .cfg_err  (cfg_err),
  .cyc_last (cyc_last)
);

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  localparam int P   = 8;
  localparam int A_W = 6;
  localparam int B_W = 13;
  localparam longint WATCHDOG = 150000;

  logic           vco = 1'b0;   // prescaler input clock, 50 MHz nominal
  logic           pre_clk = 1'b0;
  logic           rst = 1'b1;
  logic [A_W-1:0] a_set = '0;
  logic [B_W-1:0] b_set = '0;
  logic           mod_sel, fb_pulse, cfg_err;

  always #10 vco = ~vco;

  pulse_swallow_div #(.A_W(A_W), .B_W(B_W)) dut (
    .pre_clk  (pre_clk),
    .rst      (rst),
    .a_set    (a_set),
    .b_set    (b_set),
    .mod_sel  (mod_sel),
    .fb_pulse (fb_pulse),
    .cfg_err  (cfg_err)
  );

  // Behavioural dual-modulus prescaler: modulus read at the last count.
  int     pcnt = 0;
  longint vcount = 0;
  int     pres_acc = 0;
  int     long_acc = 0;
  always @(posedge vco) begin
    vcount <= vcount + 1;
    if (pcnt >= ((mod_sel === 1'b1) ? P : P - 1)) begin
      pcnt     <= 0;
      pre_clk  <= 1'b1;
      pres_acc <= pres_acc + 1;
      long_acc <= long_acc + ((mod_sel === 1'b1) ? 1 : 0);
    end else begin
      pcnt    <= pcnt + 1;
      pre_clk <= 1'b0;
    end
  end

  typedef struct {
    int n;
    int longs;
    int cyc;
    bit err;
    bit trans;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  bit   run    = 1'b0;
  event fb_ev;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Independent restatement of the divide arithmetic.
  function automatic exp_t model(input int a, input int b);
    exp_t e;
    e.cyc   = (b < 1) ? 1 : b;
    e.longs = (a < e.cyc) ? a : e.cyc;
    e.n     = e.cyc * P + e.longs;
    e.err   = (b < a);
    e.trans = 1'b0;
    return e;
  endfunction

  // Monitor: compares each finished period with the queued expectation.
  bit     prev_fb = 1'b0;
  bit     seen = 1'b0;
  longint t0;
  int     p0, l0;
  bit     err0;
  always @(negedge vco) begin
    if (run) begin
      if (fb_pulse && !prev_fb) begin
        if (seen && q.size() > 0) begin
          exp_t e;
          string rq;
          e  = q.pop_front();
          rq = e.trans ? "R6" : "R4";
          chk(vcount - t0 == e.n, rq, "period in input cycles", vcount - t0, e.n);
          chk(pres_acc - p0 == e.cyc, "R1", "prescaler cycles per period", pres_acc - p0, e.cyc);
          chk(long_acc - l0 == e.longs, e.longs == 0 ? "R5" : "R2", "long cycles", long_acc - l0, e.longs);
          chk(err0 == e.err, "R7", "cfg_err", err0, e.err);
        end
        seen = 1'b1;
        t0   = vcount;
        p0   = pres_acc;
        l0   = long_acc;
        err0 = cfg_err;
        ->fb_ev;
      end else if (!fb_pulse && prev_fb) begin
        chk(pres_acc - p0 == 1, "R9", "fb_pulse width in prescaler cycles", pres_acc - p0, 1);
      end
      prev_fb = fb_pulse;
    end
  end

  exp_t cur;

  // Driver: new pair right after a reload, short excursion mid-period.
  task automatic apply(input int a, input int b, input int k);
    @(fb_ev);
    a_set = A_W'(a);
    b_set = B_W'(b);
    cur.trans = 1'b1;
    q.push_back(cur);
    repeat (cur.n / 2) @(negedge vco);
    a_set = ~A_W'(a);
    b_set = B_W'(3);
    repeat (3) @(negedge vco);
    a_set = A_W'(a);
    b_set = B_W'(b);
    cur = model(a, b);
    for (int i = 1; i < k; i++) begin
      @(fb_ev);
      q.push_back(cur);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge vco) begin
    if (vcount > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", vcount, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R8: reset state with a legal pair
    a_set = 6'd5;
    b_set = 13'd20;
    rst   = 1'b1;
    repeat (3) @(posedge pre_clk);
    @(negedge vco);
    chk(fb_pulse == 1'b0, "R8", "fb_pulse in reset", fb_pulse, 0);
    chk(mod_sel == 1'b1, "R8", "mod_sel in reset with A=5", mod_sel, 1);
    chk(cfg_err == 1'b0, "R8", "cfg_err in reset, legal pair", cfg_err, 0);
    // R7/R8: illegal pair loaded during reset
    a_set = 6'd9;
    b_set = 13'd3;
    repeat (2) @(posedge pre_clk);
    @(negedge vco);
    chk(cfg_err == 1'b1, "R7", "cfg_err in reset, B<A", cfg_err, 1);
    a_set = 6'd0;
    repeat (2) @(posedge pre_clk);
    @(negedge vco);
    chk(mod_sel == 1'b0, "R8", "mod_sel in reset with A=0", mod_sel, 0);
    a_set = 6'd5;
    b_set = 13'd20;
    repeat (2) @(posedge pre_clk);
    @(negedge vco);
    cur = model(5, 20);
    run = 1'b1;
    rst = 1'b0;

    apply(0, 20, 2);    // R5: no swallow
    apply(63, 63, 2);   // A equals B
    apply(10, 4, 2);    // R7: illegal pair
    apply(1, 2, 2);     // smallest legal B
    apply(37, 60, 2);
    apply(0, 2, 2);
    for (int i = 0; i < 12; i++) begin
      int a, b;
      a = $urandom_range(0, 63);
      b = $urandom_range((a < 2) ? 2 : a, a + 40);
      apply(a, b, 2);
    end
    @(fb_ev);
    @(negedge vco);
    chk(q.size() == 0, "R4", "expectations left over", q.size(), 0);
    finish_run();
  end
endmodule